// File: doc/BRIEF.md
# Compare Timer with Guarded Flag Clearing

This block is a small timer peripheral on a byte-wide register bus. A 16-bit up-counter advances on a tick chosen from one of three sources: every bus clock cycle, a fixed-rate strobe or an external strobe. A power-of-two prescaler slows that tick down. A single compare channel watches the counter. When the counter reaches the programmed compare value, the channel raises a flag and, if its enable is set, an interrupt request. A second flag marks the counter rolling over from all ones to zero, and it has its own interrupt enable.

Software cannot clear either flag with a blind write. The bus must first read the register that holds the flag while the flag is 1. A later write of 0 to the flag bit then clears it. A read-modify-write sequence meets this rule. A whole-byte write that was not preceded by such a read leaves the flag set. Software typically runs a periodic tick by adding a fixed period to the previous compare value in the interrupt handler, so interrupt latency does not accumulate.

Top module: `otc_timer`

## Requirements
- R1: After reset every register reads zero, the counter holds at zero and both interrupt requests are low.
- R2: Register at address 0 holds prescale in bits 2:0, source in bits 4:3, center mode in bit 5, rollover interrupt enable in bit 6 and the rollover flag in bit 7. While the source field is 00 the counter does not move.
- R3: Source field 01 advances the counter on every clock cycle. Source 10 advances it once per `fix_tick` pulse. Source 11 advances it once per `ext_tick` pulse.
- R4: With prescale value P, the counter advances once per 2^P selected ticks.
- R5: Register at address 3 holds the channel flag in bit 7, the channel interrupt enable in bit 6, the mode pair in bits 5:4 and the edge pair in bits 3:2. Bits 1:0 read 0. `irq_ch` is high exactly while the flag and the enable are both 1.
- R6: When the mode pair is bit4=1 and bit5=0 and center mode is off, the channel flag sets on the clock edge where the counter becomes equal to the compare value. This happens once per match. The edge pair drives nothing and does not affect the flag. With any other mode setting, a match sets no flag.
- R7: The rollover flag sets on the edge where the counter wraps from 0xFFFF to 0x0000. `irq_ovf` is high while that flag and bit 6 of register 0 are both 1.
- R8: A read strobe to a flag's register while the flag is 1, followed later by a write of 0 to that flag bit, clears the flag.
- R9: A write of 0 to a flag bit with no earlier qualifying read leaves the flag set. Any write to the register uses up an earlier qualifying read.
- R10: If a new event arrives on the same edge as a clearing write, the flag stays set.
- R11: The counter reads at address 1 (high byte) and address 2 (low byte), and writes to these addresses are ignored. The compare value is written at address 4 (high byte) and address 5 (low byte), may be rewritten at any time, and takes effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fix_tick | input | 1 | Fixed-rate tick strobe, one cycle wide |
| ext_tick | input | 1 | External tick strobe, one cycle wide |
| bus_addr | input | 3 | Byte register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; arms flag clearing |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_ovf | output | 1 | Rollover interrupt request |
| irq_ch | output | 1 | Channel compare interrupt request |

## Verification
The hardest case to reach is a clearing write that lands on the same edge as a new compare event. The flag must already be set and armed for that write to matter. To get there, the bench stops the counter, arms the flag with a read, and programs the compare value three counts ahead. It then restarts the counter and times the clearing write to land on the third counter edge. Exact edge timing of the flag is also checked after a frozen-counter setup. Rollover is reached by letting the counter run through its full range at the bus clock rate.

// File: rtl/otc_pkg.sv
package otc_pkg;
    localparam int CNT_W  = 16;
    localparam int PS_W   = 3;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    localparam int FLG_OVF = 0;
    localparam int FLG_CH  = 1;
    localparam int NFLAG   = 2;

    localparam logic [ADDR_W-1:0] A_GCTL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNTH  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNTL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CHCTL = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMPH  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMPL  = 3'd5;

    typedef enum logic [1:0] {
        SRC_OFF = 2'b00,
        SRC_BUS = 2'b01,
        SRC_FIX = 2'b10,
        SRC_EXT = 2'b11
    } clk_src_e;

    typedef struct packed {
        logic             toie;
        logic             cpwm;
        clk_src_e         clks;
        logic [PS_W-1:0]  ps;
        logic             ch_ie;
        logic             ch_msb;
        logic             ch_msa;
        logic             ch_elb;
        logic             ch_ela;
        logic [CNT_W-1:0] cmp;
    } regs_t;
endpackage

// File: rtl/otc_prescale.sv
module otc_prescale
    import otc_pkg::*;
#(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  clk_src_e        src,
    input  logic [PS_W-1:0] ps,
    input  logic            fix_tick,
    input  logic            ext_tick,
    output logic            cnt_en
);
    localparam int PRE_W = (1 << PS_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_t;

    pre_t             s_q, s_d;
    logic             tick;
    logic [PRE_W-1:0] mask;

    always_comb begin
        unique case (src)
            SRC_BUS: tick = 1'b1;
            SRC_FIX: tick = fix_tick;
            SRC_EXT: tick = ext_tick;
            default: tick = 1'b0;
        endcase
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(ps));
        end
        cnt_en = tick && ((s_q.pre & mask) == mask);
        s_d = s_q;
        if (src == SRC_OFF) begin
            s_d.pre = '0;
        end else if (tick) begin
            s_d.pre = s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/otc_counter.sv
module otc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_nxt = cnt_q + 1'b1;
        wrap    = en && (&cnt_q);
        cnt_d   = en ? cnt_nxt : cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/otc_flag.sv
module otc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic flag_q,
    output logic arm_q
);
    typedef struct packed {
        logic flag;
        logic arm;
    } flg_t;

    flg_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (rd_hit && s_q.flag) s_d.arm = 1'b1;
        if (wr_hit) begin
            s_d.arm = 1'b0;
            if (s_q.arm && !wr_bit) s_d.flag = 1'b0;
        end
        if (set_evt) s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag_q = s_q.flag;
    assign arm_q  = s_q.arm;
endmodule

// File: rtl/otc_timer.sv
module otc_timer
    import otc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fix_tick,
    input  logic              ext_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_ovf,
    output logic              irq_ch
);
    localparam int FLAG_BIT = DATA_W - 1;

    regs_t            r_q, r_d;
    logic             cnt_en, wrap, oc_mode, match;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic [NFLAG-1:0] set_evt, rd_hit, wr_hit, wr_bit, flag_q, arm_q;
    logic             hit_gctl_w, hit_chctl_w, hit_cmph_w, hit_cmpl_w;
    logic [1:0]       gclks;
    logic             ch_flag, ch_arm, ch_wr_hit, ovf_flag, ch_ie;

    always_comb begin
        hit_gctl_w  = bus_wr && (bus_addr == A_GCTL);
        hit_chctl_w = bus_wr && (bus_addr == A_CHCTL);
        hit_cmph_w  = bus_wr && (bus_addr == A_CMPH);
        hit_cmpl_w  = bus_wr && (bus_addr == A_CMPL);

        r_d = r_q;
        if (hit_gctl_w) begin
            r_d.toie = bus_wdata[6];
            r_d.cpwm = bus_wdata[5];
            r_d.clks = clk_src_e'(bus_wdata[4:3]);
            r_d.ps   = bus_wdata[PS_W-1:0];
        end
        if (hit_chctl_w) begin
            r_d.ch_ie  = bus_wdata[6];
            r_d.ch_msb = bus_wdata[5];
            r_d.ch_msa = bus_wdata[4];
            r_d.ch_elb = bus_wdata[3];
            r_d.ch_ela = bus_wdata[2];
        end
        if (hit_cmph_w) r_d.cmp[CNT_W-1:DATA_W] = bus_wdata;
        if (hit_cmpl_w) r_d.cmp[DATA_W-1:0]     = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    otc_prescale #(.PS_W(PS_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (r_q.clks),
        .ps       (r_q.ps),
        .fix_tick (fix_tick),
        .ext_tick (ext_tick),
        .cnt_en   (cnt_en)
    );

    otc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cnt_en),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .wrap    (wrap)
    );

    always_comb begin
        oc_mode = r_q.ch_msa && !r_q.ch_msb && !r_q.cpwm;
        match   = cnt_en && oc_mode && (cnt_nxt == r_q.cmp);

        set_evt[FLG_OVF] = wrap;
        set_evt[FLG_CH]  = match;
        rd_hit[FLG_OVF]  = bus_rd && (bus_addr == A_GCTL);
        rd_hit[FLG_CH]   = bus_rd && (bus_addr == A_CHCTL);
        wr_hit[FLG_OVF]  = hit_gctl_w;
        wr_hit[FLG_CH]   = hit_chctl_w;
        wr_bit           = {NFLAG{bus_wdata[FLAG_BIT]}};
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        otc_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (set_evt[g]),
            .rd_hit  (rd_hit[g]),
            .wr_hit  (wr_hit[g]),
            .wr_bit  (wr_bit[g]),
            .flag_q  (flag_q[g]),
            .arm_q   (arm_q[g])
        );
    end

    always_comb begin
        unique case (bus_addr)
            A_GCTL:  bus_rdata = {flag_q[FLG_OVF], r_q.toie, r_q.cpwm,
                                  r_q.clks, r_q.ps};
            A_CNTH:  bus_rdata = cnt_q[CNT_W-1:DATA_W];
            A_CNTL:  bus_rdata = cnt_q[DATA_W-1:0];
            A_CHCTL: bus_rdata = {flag_q[FLG_CH], r_q.ch_ie, r_q.ch_msb,
                                  r_q.ch_msa, r_q.ch_elb, r_q.ch_ela, 2'b00};
            A_CMPH:  bus_rdata = r_q.cmp[CNT_W-1:DATA_W];
            A_CMPL:  bus_rdata = r_q.cmp[DATA_W-1:0];
            default: bus_rdata = '0;
        endcase
    end

    assign irq_ovf   = flag_q[FLG_OVF] && r_q.toie;
    assign irq_ch    = flag_q[FLG_CH] && r_q.ch_ie;

    assign gclks     = r_q.clks;
    assign ch_flag   = flag_q[FLG_CH];
    assign ch_arm    = arm_q[FLG_CH];
    assign ch_wr_hit = wr_hit[FLG_CH];
    assign ovf_flag  = flag_q[FLG_OVF];
    assign ch_ie     = r_q.ch_ie;
endmodule

// File: rtl/otc_timer_chk.sv
module otc_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic [CNT_W-1:0] cnt_q,
    input logic [1:0]       gclks,
    input logic             ch_flag,
    input logic             ch_arm,
    input logic             ch_wr_hit,
    input logic             ovf_flag,
    input logic             irq_ch,
    input logic             ch_ie
);
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (gclks == 2'b00) |=> $stable(cnt_q)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) cnt_en |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R3
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !cnt_en |=> $stable(cnt_q)); // R4
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n) irq_ch |-> (ch_ie && ch_flag)); // R5
    AST_CH_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ch_flag) |-> $past(cnt_en)); // R6
    AST_OVF_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf_flag) |-> (cnt_q == '0)); // R7
    AST_CH_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(ch_flag) |-> ($past(ch_arm) && $past(ch_wr_hit))); // R8
endmodule

bind otc_timer otc_timer_chk #(.CNT_W(otc_pkg::CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .cnt_q     (cnt_q),
    .gclks     (gclks),
    .ch_flag   (ch_flag),
    .ch_arm    (ch_arm),
    .ch_wr_hit (ch_wr_hit),
    .ovf_flag  (ovf_flag),
    .irq_ch    (irq_ch),
    .ch_ie     (ch_ie)
);

// File: tb/tb_otc_timer.sv
module tb_otc_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fix_tick = 1'b0;
    logic       ext_tick = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_ovf, irq_ch;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [7:0] CH_OC_IE = 8'h50;

    always #10 clk = ~clk;

    otc_timer dut (
        .clk(clk), .rst_n(rst_n), .fix_tick(fix_tick), .ext_tick(ext_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ovf(irq_ovf), .irq_ch(irq_ch)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1; #1; d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic get_cnt(output logic [15:0] c);
        logic [7:0] h, l;
        peek(3'd1, h); peek(3'd2, l);
        c = {h, l};
    endtask

    task automatic set_cmp(input logic [15:0] v);
        wr(3'd4, v[15:8]); wr(3'd5, v[7:0]);
    endtask

    task automatic ch_flag(output logic f);
        logic [7:0] d;
        peek(3'd3, d); f = d[7];
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 6; a++) begin
            peek(3'(a), d);
            check("R1 reset reg", d, 8'h00);
        end
        check("R1 irq_ovf", irq_ovf, 1'b0);
        check("R1 irq_ch", irq_ch, 1'b0);
    endtask

    task automatic t_stopped;
        logic [15:0] c0, c1;
        logic [7:0] d;
        wr(3'd0, 8'h03);
        peek(3'd0, d);
        check("R2 prescale field readback", d, 8'h03);
        get_cnt(c0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        get_cnt(c1);
        check("R2 stopped source", c1, c0);
        wr(3'd1, 8'hAA); wr(3'd2, 8'h55);
        get_cnt(c1);
        check("R11 counter write ignored", c1, c0);
    endtask

    task automatic t_bus;
        logic [15:0] c0, c1;
        wr(3'd0, 8'h08);
        get_cnt(c0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        get_cnt(c1);
        check("R3 bus clock rate", 32'(c1 - c0), 32'd10);
    endtask

    task automatic t_presc;
        logic [15:0] c0, c1;
        wr(3'd0, 8'h0B);
        get_cnt(c0);
        repeat (80) @(posedge clk);
        @(negedge clk);
        get_cnt(c1);
        check("R4 prescale 8", 32'(c1 - c0), 32'd10);
        wr(3'd0, 8'h09);
        get_cnt(c0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        get_cnt(c1);
        check("R4 prescale 2", 32'(c1 - c0), 32'd10);
    endtask

    task automatic t_ticks;
        logic [15:0] c0, c1;
        wr(3'd0, 8'h10);
        get_cnt(c0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        get_cnt(c1);
        check("R3 fixed source idle", c1, c0);
        for (int i = 0; i < 5; i++) begin
            fix_tick = 1'b1; ext_tick = 1'b1;
            @(posedge clk); @(negedge clk);
            fix_tick = 1'b0; ext_tick = 1'b0;
            @(posedge clk); @(negedge clk);
        end
        get_cnt(c1);
        check("R3 fixed source pulses", 32'(c1 - c0), 32'd5);
        wr(3'd0, 8'h18);
        get_cnt(c0);
        for (int i = 0; i < 3; i++) begin
            ext_tick = 1'b1;
            @(posedge clk); @(negedge clk);
            ext_tick = 1'b0;
            fix_tick = 1'b1;
            @(posedge clk); @(negedge clk);
            fix_tick = 1'b0;
        end
        get_cnt(c1);
        check("R3 external source pulses", 32'(c1 - c0), 32'd3);
    endtask

    task automatic t_compare;
        logic [15:0] c, c1;
        logic f;
        wr(3'd0, 8'h00);
        get_cnt(c);
        set_cmp(c + 16'd5);
        wr(3'd3, CH_OC_IE);
        wr(3'd0, 8'h08);
        repeat (4) @(posedge clk);
        @(negedge clk);
        ch_flag(f);
        check("R6 no flag before match", f, 1'b0);
        check("R5 irq low before match", irq_ch, 1'b0);
        @(posedge clk); @(negedge clk);
        ch_flag(f);
        get_cnt(c1);
        check("R6 flag on match edge", f, 1'b1);
        check("R6 counter at match", c1, c + 16'd5);
        check("R5 irq with enable", irq_ch, 1'b1);
    endtask

    task automatic t_clear;
        logic [7:0] d;
        logic f;
        wr(3'd3, CH_OC_IE);
        ch_flag(f);
        check("R9 blind write keeps flag", f, 1'b1);
        rd(3'd3, d);
        check("R5 channel readback", d, 8'hD0);
        wr(3'd3, CH_OC_IE);
        ch_flag(f);
        check("R8 read then write clears", f, 1'b0);
        check("R8 irq drops", irq_ch, 1'b0);
        repeat (50) @(posedge clk);
        @(negedge clk);
        ch_flag(f);
        check("R6 once per match", f, 1'b0);
    endtask

    task automatic t_period;
        logic [15:0] c, c1;
        logic f;
        bit seen = 1'b0;
        get_cnt(c);
        set_cmp(c + 16'd100);
        for (int i = 0; i < 400 && !seen; i++) begin
            @(posedge clk); @(negedge clk);
            ch_flag(f);
            if (f) seen = 1'b1;
        end
        get_cnt(c1);
        check("R11 rewritten compare fires", seen, 1'b1);
        check("R11 counter equals new compare", c1, c + 16'd100);
    endtask

    task automatic t_race;
        logic [15:0] c;
        logic [7:0] d;
        logic f;
        wr(3'd0, 8'h00);
        get_cnt(c);
        rd(3'd3, d);
        set_cmp(c + 16'd3);
        wr(3'd0, 8'h08);
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr(3'd3, CH_OC_IE);
        ch_flag(f);
        check("R10 event beats clear", f, 1'b1);
        wr(3'd3, CH_OC_IE);
        ch_flag(f);
        check("R9 arm used by write", f, 1'b1);
        rd(3'd3, d);
        wr(3'd3, CH_OC_IE);
        ch_flag(f);
        check("R8 clear after race", f, 1'b0);
    endtask

    task automatic t_mode_off;
        logic [15:0] c;
        logic f;
        wr(3'd3, 8'h4C);
        get_cnt(c);
        set_cmp(c + 16'd20);
        repeat (60) @(posedge clk);
        @(negedge clk);
        ch_flag(f);
        check("R6 other mode no flag", f, 1'b0);
        check("R5 irq low other mode", irq_ch, 1'b0);
    endtask

    task automatic t_overflow;
        logic [7:0] d;
        logic [15:0] c;
        bit seen = 1'b0;
        wr(3'd0, 8'h48);
        for (int i = 0; i < 70000 && !seen; i++) begin
            @(posedge clk); @(negedge clk);
            peek(3'd0, d);
            if (d[7]) seen = 1'b1;
        end
        get_cnt(c);
        check("R7 rollover flag", seen, 1'b1);
        check("R7 counter after wrap", c, 16'h0000);
        check("R7 irq_ovf", irq_ovf, 1'b1);
        wr(3'd0, 8'h48);
        peek(3'd0, d);
        check("R9 rollover blind write", d[7], 1'b1);
        rd(3'd0, d);
        wr(3'd0, 8'h48);
        peek(3'd0, d);
        check("R8 rollover cleared", d[7], 1'b0);
        check("R7 irq_ovf drops", irq_ovf, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stopped();
        t_bus();
        t_presc();
        t_ticks();
        t_compare();
        t_clear();
        t_period();
        t_race();
        t_mode_off();
        t_overflow();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule